// File: doc/BRIEF.md
# Non-Restoring Divide Step Unit

This unit divides a 32-bit dividend by a 16-bit divisor with the non-restoring add/subtract method. It produces one quotient bit per clock. The dividend is held in two 16-bit registers, an upper half and a lower half. Every step shifts the pair left by one bit. A single status bit, the quotient-sign bit, carries between steps and decides whether the next step adds or subtracts the divisor. The quotient builds up in the lower register. The upper register holds the running partial remainder, and this remainder is not corrected at the end.

A request is one start pulse while the unit is idle, together with the operands and a mode flag. The dividend and the divisor are both signed or both unsigned. Signed division spends its first cycle on a sign-setup step, then runs 15 quotient steps. Unsigned division clears the quotient-sign bit and runs 16 quotient steps. Either way a divide takes 16 step cycles, and a single-cycle done pulse follows it. Both registers can be seen at the outputs on every cycle. Divide overflow is not detected.

Top module: `nrd_div_step_unit`

## Requirements
- R1: While rst_ni is low, quot_o, rem_o, busy_o and done_o are all zero.
- R2: When start_i is high and busy_o is low at a clock edge, the unit captures dvd_hi_i into the upper register (rem_o), dvd_lo_i into the lower register (quot_o), and divisor_i and signed_i as well. busy_o then stays high for exactly 16 cycles.
- R3: The sign-setup step computes s = upper[15] XOR divisor[15] and stores s in the quotient-sign bit. It sets the new lower register to {lower[14:0], s} and the new upper register to {upper[14:0], lower[15]}.
- R4: A quotient step forms r = upper + divisor when the quotient-sign bit is 1, and r = upper - divisor (modulo 2^16) when it is 0. It then sets the new upper register to {r[14:0], lower[15]}.
- R5: After a quotient step, the quotient-sign bit becomes r[15] XOR divisor[15]. The new lower register is {lower[14:0], NOT that bit}.
- R6: An unsigned request (signed_i = 0) starts with the quotient-sign bit at 0 and performs 16 quotient steps.
- R7: A signed request (signed_i = 1) performs one sign-setup step as its first step and 15 quotient steps after it.
- R8: done_o is high for exactly one cycle, namely the cycle after the final step. busy_o is low in that cycle, and quot_o and rem_o hold the final lower and upper registers.
- R9: start_i has no effect while busy_o is high. The running divide goes on with its captured operands.
- R10: While idle and without a start, quot_o and rem_o hold their values whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a divide when idle |
| signed_i | input | 1 | 1 = signed operands, 0 = unsigned |
| divisor_i | input | 16 | Divisor |
| dvd_hi_i | input | 16 | Upper half of the dividend |
| dvd_lo_i | input | 16 | Lower half of the dividend |
| quot_o | output | 16 | Lower register; holds the quotient at the end |
| rem_o | output | 16 | Upper register; partial remainder |
| busy_o | output | 1 | A divide is running |
| done_o | output | 1 | One-cycle pulse after the last step |

## Verification
The bench aims at the operand signs that change the direction of the first add or subtract. These are a negative dividend, a negative divisor, and the two together. A design that took the sign of the wrong operand, or that let the add/subtract choice lag a step behind, shows a wrong quot_o bit within one cycle. It also starts requests in the done cycle and in the middle of a run. A counter off by one would stretch or clip busy_o, and a unit that did not guard its start would pick up the new operands in the middle of a run. Idle cycles with changing inputs catch registers that load without a start.

// File: rtl/nrd_pkg.sv
package nrd_pkg;
  typedef enum logic [1:0] {
    STEP_IDLE = 2'd0,
    STEP_SIGN = 2'd1,
    STEP_QUOT = 2'd2
  } step_kind_e;
endpackage

// File: rtl/nrd_addsub.sv
module nrd_addsub #(
  parameter int W = 16
) (
  input  logic                  pass_i,
  input  logic                  add_i,
  input  logic [W-1:0]          a_i,
  input  logic [W-1:0]          b_i,
  output logic [W-1:0]          r_o
);
  always_comb begin
    if (pass_i)     r_o = a_i;
    else if (add_i) r_o = a_i + b_i;
    else            r_o = a_i - b_i;
  end
endmodule

// File: rtl/nrd_pair_shift.sv
module nrd_pair_shift
  import nrd_pkg::*;
#(
  parameter int W = 16
) (
  input  step_kind_e    kind_i,
  input  logic [W-1:0]  hi_i,
  input  logic [W-1:0]  lo_i,
  input  logic [W-1:0]  alu_r_i,
  input  logic          div_msb_i,
  input  logic          aq_i,
  output logic [W-1:0]  hi_o,
  output logic [W-1:0]  lo_o,
  output logic          aq_o
);
  logic ins_bit;

  always_comb begin
    aq_o    = aq_i;
    ins_bit = 1'b0;
    hi_o    = hi_i;
    lo_o    = lo_i;
    unique case (kind_i)
      STEP_SIGN: begin
        aq_o    = hi_i[W-1] ^ div_msb_i;
        ins_bit = aq_o;
        hi_o    = {alu_r_i[W-2:0], lo_i[W-1]};
        lo_o    = {lo_i[W-2:0], ins_bit};
      end
      STEP_QUOT: begin
        aq_o    = alu_r_i[W-1] ^ div_msb_i;
        ins_bit = ~aq_o;
        hi_o    = {alu_r_i[W-2:0], lo_i[W-1]};
        lo_o    = {lo_i[W-2:0], ins_bit};
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/nrd_ctrl.sv
module nrd_ctrl
  import nrd_pkg::*;
#(
  parameter int STEPS = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       signed_i,
  output logic       load_o,
  output step_kind_e kind_o,
  output logic       busy_o,
  output logic       done_o
);
  localparam int CW = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q, done_q, sgn_q;

  assign load_o = start_i && !busy_q;
  assign busy_o = busy_q;
  assign done_o = done_q;

  always_comb begin
    if (!busy_q)                         kind_o = STEP_IDLE;
    else if (sgn_q && cnt_q == '0)       kind_o = STEP_SIGN;
    else                                 kind_o = STEP_QUOT;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      sgn_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (busy_q) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == LAST) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          cnt_q  <= '0;
        end
      end else if (start_i) begin
        busy_q <= 1'b1;
        sgn_q  <= signed_i;
        cnt_q  <= '0;
      end
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q); // R8
  AST_DONE_ENDS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && cnt_q == LAST) |=> (done_q && !busy_q)); // R8
  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && start_i && cnt_q != LAST) |=> (busy_q && $stable(sgn_q))); // R9
  AST_SIGN_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_o == STEP_SIGN) |-> (cnt_q == '0 && sgn_q)); // R7
endmodule

// File: rtl/nrd_div_step_unit.sv
module nrd_div_step_unit
  import nrd_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         signed_i,
  input  logic [W-1:0] divisor_i,
  input  logic [W-1:0] dvd_hi_i,
  input  logic [W-1:0] dvd_lo_i,
  output logic [W-1:0] quot_o,
  output logic [W-1:0] rem_o,
  output logic         busy_o,
  output logic         done_o
);
  localparam int STEPS = W;

  logic [W-1:0] hi_q, lo_q, div_q, alu_r, hi_n, lo_n;
  logic         aq_q, aq_n, load;
  step_kind_e   kind;

  nrd_ctrl #(.STEPS(STEPS)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .signed_i (signed_i),
    .load_o   (load),
    .kind_o   (kind),
    .busy_o   (busy_o),
    .done_o   (done_o)
  );

  nrd_addsub #(.W(W)) u_alu (
    .pass_i (kind == STEP_SIGN),
    .add_i  (aq_q),
    .a_i    (hi_q),
    .b_i    (div_q),
    .r_o    (alu_r)
  );

  nrd_pair_shift #(.W(W)) u_shift (
    .kind_i    (kind),
    .hi_i      (hi_q),
    .lo_i      (lo_q),
    .alu_r_i   (alu_r),
    .div_msb_i (div_q[W-1]),
    .aq_i      (aq_q),
    .hi_o      (hi_n),
    .lo_o      (lo_n),
    .aq_o      (aq_n)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q  <= '0;
      lo_q  <= '0;
      div_q <= '0;
      aq_q  <= 1'b0;
    end else if (load) begin
      hi_q  <= dvd_hi_i;
      lo_q  <= dvd_lo_i;
      div_q <= divisor_i;
      aq_q  <= 1'b0;
    end else if (busy_o) begin
      hi_q <= hi_n;
      lo_q <= lo_n;
      aq_q <= aq_n;
    end
  end

  assign quot_o = lo_q;
  assign rem_o  = hi_q;

  AST_PAIR_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !load) |=> hi_q[0] == $past(lo_q[W-1])); // R4
  AST_SIGN_SETUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind == STEP_SIGN) |=> (aq_q == ($past(hi_q[W-1]) ^ div_q[W-1]) && lo_q[0] == aq_q)); // R3
  AST_QBIT_INVERSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind == STEP_QUOT) |=> lo_q[0] == !aq_q); // R5
  AST_UNSIGNED_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load && !signed_i) |=> !aq_q); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !load) |=> ($stable(hi_q) && $stable(lo_q))); // R10
  AST_DIVISOR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !$past(load)) |-> $stable(div_q)); // R9
endmodule

// File: tb/nrd_div_step_unit_test.sv
`timescale 1ns/1ps
module nrd_div_step_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, sgn = 1'b0;
  logic [15:0] dvs = '0, dhi = '0, dlo = '0;
  logic [15:0] quot, rem;
  logic        busy, done;

  int n_chk = 0, n_bad = 0;

  // model state
  logic [15:0] m_hi = '0, m_lo = '0, m_div = '0;
  logic        m_aq = 1'b0, m_busy = 1'b0, m_done = 1'b0, m_sgn = 1'b0;
  int          m_cnt = 0;
  string       m_tag = "R1";

  always #2.5 clk = ~clk;

  nrd_div_step_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .signed_i(sgn),
    .divisor_i(dvs), .dvd_hi_i(dhi), .dvd_lo_i(dlo),
    .quot_o(quot), .rem_o(rem), .busy_o(busy), .done_o(done));

  task automatic chk(string what, string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic model_step();
    int r;
    m_done = 1'b0;
    if (m_busy) begin
      if (m_sgn && m_cnt == 0) begin
        m_tag = "R3/R7";
        m_aq  = m_hi[15] ^ m_div[15];
        m_hi  = {m_hi[14:0], m_lo[15]};
        m_lo  = {m_lo[14:0], m_aq};
      end else begin
        m_tag = m_sgn ? "R4/R5/R7" : "R4/R5/R6";
        r = m_aq ? (int'(m_hi) + int'(m_div)) : (int'(m_hi) - int'(m_div));
        r = r & 16'hFFFF;
        m_aq = r[15] ^ m_div[15];
        m_hi = {r[14:0], m_lo[15]};
        m_lo = {m_lo[14:0], ~m_aq};
      end
      m_cnt++;
      if (start) m_tag = {m_tag, "/R9"};
      if (m_cnt == 16) begin
        m_busy = 1'b0;
        m_done = 1'b1;
        m_tag  = {m_tag, "/R8"};
      end
    end else if (start) begin
      m_tag  = "R2";
      m_hi   = dhi;
      m_lo   = dlo;
      m_div  = dvs;
      m_sgn  = sgn;
      m_aq   = 1'b0;
      m_cnt  = 0;
      m_busy = 1'b1;
    end else begin
      m_tag = "R10";
    end
  endtask

  task automatic cyc(logic st, logic sg, logic [15:0] h, logic [15:0] l, logic [15:0] d);
    start = st; sgn = sg; dhi = h; dlo = l; dvs = d;
    model_step();
    @(posedge clk);
    @(negedge clk);
    chk("quot_o", m_tag, quot, m_lo);
    chk("rem_o",  m_tag, rem,  m_hi);
    chk("busy_o", m_busy ? "R2" : m_tag, busy, m_busy);
    chk("done_o", "R8", done, m_done);
  endtask

  task automatic run_div(logic sg, logic [15:0] h, logic [15:0] l, logic [15:0] d);
    cyc(1'b1, sg, h, l, d);
    for (int i = 0; i < 16; i++) cyc(1'b0, ~sg, ~h, ~l, ~d);
  endtask

  initial begin
    #100000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    start = 1'b1; dhi = 16'h1234; dlo = 16'h5678; dvs = 16'h9abc;
    repeat (3) @(negedge clk);
    chk("quot_o reset", "R1", quot, 0);
    chk("rem_o reset",  "R1", rem, 0);
    chk("busy_o reset", "R1", busy, 0);
    chk("done_o reset", "R1", done, 0);
    start = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);

    run_div(1'b0, 16'h0000, 16'd100, 16'd7);          // R6 unsigned
    run_div(1'b1, 16'hFFFF, 16'hFF9C, 16'd7);          // R7 negative dividend
    run_div(1'b1, 16'h0000, 16'd100, 16'hFFF9);        // R3 negative divisor
    run_div(1'b1, 16'hFFFF, 16'hFF9C, 16'hFFF9);       // R3 both negative
    run_div(1'b0, 16'h0003, 16'h8001, 16'h8000);       // R4 divisor MSB set
    // R8: restart in the done cycle
    cyc(1'b1, 1'b1, 16'h0001, 16'h2345, 16'h0100);
    for (int i = 0; i < 16; i++) cyc(1'b0, 1'b0, '0, '0, '0);
    cyc(1'b1, 1'b0, 16'h0010, 16'hABCD, 16'h0400);
    // R9: start pulses during the run
    for (int i = 0; i < 16; i++) cyc(i[0], 1'b1, 16'hFFFF, 16'hFFFF, 16'h0001);
    // R10: idle with changing inputs
    for (int i = 0; i < 6; i++) cyc(1'b0, i[0], 16'(i * 777), 16'(i * 4099), 16'(i * 31));
    for (int k = 0; k < 40; k++) begin
      logic [15:0] d;
      d = 16'($urandom);
      if (d == 0) d = 16'd3;
      cyc(1'b1, 1'($urandom), 16'($urandom), 16'($urandom), d);
      for (int i = 0; i < 16 + (k % 3); i++)
        cyc(($urandom % 4) == 0, 1'($urandom), 16'($urandom), 16'($urandom), 16'($urandom));
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule